// File: doc/BRIEF.md
# Burst Line-Transfer Bus Controller

This block is the master side of a burst bus between a cache controller and main memory. It moves one cache line of four 64-bit doublewords per request. The cache presents a line address, a direction, and for writes the whole line. The controller latches them, drives the line address and a request-pending level onto the bus, and then follows the memory's ready strobe.

Memory raises ready one cycle before each data beat. In the cycle after a ready, a write beat takes the controller's write data and a read beat returns the memory's data to the cache with a valid strobe and the doubleword index. Request-pending stays high until three readies have been seen. The fourth ready therefore arrives while request-pending is low, and memory reads that as the final beat. One cycle after the final beat the controller pulses done and returns to idle. It takes a new request only while idle.

Top module: `burst_bus_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1 and bus_req_o, bus_write_o, rd_valid_o and done_o are 0.
- R2: A request is taken only in a cycle where req_ready_o is 1, and req_ready_o is 1 only while idle. A req_valid_i held high during a transfer has no effect on the transfer's address, direction or data.
- R3: bus_req_o rises in the cycle after a request is accepted. It stays high until three bus_rdy_i pulses of that transfer have been sampled, and is low from the following cycle onward.
- R4: bus_addr_o carries the accepted line address for the whole transfer. bus_write_o carries the accepted direction (1 = write) for the whole transfer.
- R5: A data beat happens exactly in the cycle after a sampled bus_rdy_i, and in no other cycle. Wait cycles between readies produce no beat. On a write beat k (k counting 0..3 in order), bus_wdata_o equals req_line_i bits [64k+63:64k] as latched at acceptance.
- R6: On a read beat k, rd_valid_o is 1, rd_beat_o equals k and rd_data_o equals bus_rdata_i of that cycle. rd_valid_o is 0 on write transfers.
- R7: The fourth ready, sampled while bus_req_o is low, gives the last beat. done_o is 1 for exactly the next cycle, and req_ready_o is 1 in the cycle after that.
- R8: A bus_rdy_i while idle, in the last-beat cycle or in the done cycle has no effect: no beat, no valid strobe and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Line request from the cache |
| req_write_i | input | 1 | 1 = write line, 0 = read line |
| req_addr_i | input | ADDR_W | Line address |
| req_line_i | input | DW*BEATS | Write line, doubleword k at bits [64k+63:64k] |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rd_valid_o | output | 1 | Read beat valid |
| rd_beat_o | output | 2 | Doubleword index of the read beat |
| rd_data_o | output | DW | Read beat data |
| bus_addr_o | output | ADDR_W | Bus line address |
| bus_write_o | output | 1 | Bus direction, 1 = write |
| bus_req_o | output | 1 | Request pending |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdy_i | input | 1 | Memory ready, one cycle ahead of each beat |
| bus_rdata_i | input | DW | Bus read data |

## Verification
The hardest cases to reach are a ready that coincides with a beat cycle and a ready that lands on the last-beat or done cycle. In the first, the beat and the next ready overlap, so the request-pending drop must happen in the same cycle as the third beat. The second must be ignored. The stimulus runs bursts with back-to-back readies, with irregular gaps, with a stray ready placed in the final beat cycle, and with stray readies while idle. It also holds the request input high across a whole transfer, so that a second request waits for idle.

// File: rtl/burst_bus_pkg.sv
package burst_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_LAST,
    ST_DONE
  } bus_st_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_bus_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int RW = $clog2(BEATS + 1)
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    rdy_i,
  output bus_st_e st_o,
  output logic    req_pend_o
);
  bus_st_e st_q, st_d;
  logic [RW-1:0] rdy_cnt_q, rdy_cnt_d;
  logic active;

  assign active     = (st_q == ST_WAIT) || (st_q == ST_XFER);
  assign req_pend_o = active && (rdy_cnt_q < RW'(BEATS - 1));
  assign st_o       = st_q;

  always_comb begin
    st_d      = st_q;
    rdy_cnt_d = rdy_cnt_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d      = ST_WAIT;
        rdy_cnt_d = '0;
      end
      ST_WAIT, ST_XFER: begin
        if (rdy_i) begin
          rdy_cnt_d = rdy_cnt_q + 1'b1;
          // ready seen with request-pending low marks the final beat
          st_d = (rdy_cnt_q == RW'(BEATS - 1)) ? ST_LAST : ST_XFER;
        end else begin
          st_d = ST_WAIT;
        end
      end
      ST_LAST: st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      rdy_cnt_q <= '0;
    end else begin
      st_q      <= st_d;
      rdy_cnt_q <= rdy_cnt_d;
    end
  end
endmodule

// File: rtl/beat_ctr.sv
module beat_ctr #(
  parameter int BEATS = 4,
  localparam int IW = $clog2(BEATS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] idx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (inc_i) idx_q <= idx_q + 1'b1;
  end
  assign idx_o = idx_q;
endmodule

// File: rtl/line_sel.sv
module line_sel #(
  parameter int DW    = 64,
  parameter int BEATS = 4,
  localparam int IW = $clog2(BEATS)
) (
  input  logic [DW*BEATS-1:0] line_i,
  input  logic [IW-1:0]       idx_i,
  output logic [DW-1:0]       data_o
);
  logic [DW-1:0] dw [BEATS];
  for (genvar g = 0; g < BEATS; g++) begin : g_dw
    assign dw[g] = line_i[g*DW +: DW];
  end
  assign data_o = dw[idx_i];
endmodule

// File: rtl/burst_bus_ctrl.sv
module burst_bus_ctrl
  import burst_bus_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DW     = 64,
  parameter int BEATS  = 4,
  localparam int IW = $clog2(BEATS),
  localparam int LW = DW * BEATS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LW-1:0]     req_line_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              rd_valid_o,
  output logic [IW-1:0]     rd_beat_o,
  output logic [DW-1:0]     rd_data_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_write_o,
  output logic              bus_req_o,
  output logic [DW-1:0]     bus_wdata_o,
  input  logic              bus_rdy_i,
  input  logic [DW-1:0]     bus_rdata_i
);
  bus_st_e st;
  logic start, beat, in_xfer;
  logic [IW-1:0] idx;
  logic [DW-1:0] sel_data;
  logic [ADDR_W-1:0] addr_q;
  logic [LW-1:0] line_q;
  logic wr_q;

  assign req_ready_o = (st == ST_IDLE);
  assign start       = req_ready_o && req_valid_i;
  assign beat        = (st == ST_XFER) || (st == ST_LAST);
  assign in_xfer     = (st == ST_WAIT) || beat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      line_q <= '0;
      wr_q   <= 1'b0;
    end else if (start) begin
      addr_q <= req_addr_i;
      line_q <= req_line_i;
      wr_q   <= req_write_i;
    end
  end

  burst_seq #(.BEATS(BEATS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rdy_i     (bus_rdy_i),
    .st_o      (st),
    .req_pend_o(bus_req_o)
  );

  beat_ctr #(.BEATS(BEATS)) u_beat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start),
    .inc_i (beat),
    .idx_o (idx)
  );

  line_sel #(.DW(DW), .BEATS(BEATS)) u_sel (
    .line_i(line_q),
    .idx_i (idx),
    .data_o(sel_data)
  );

  assign done_o      = (st == ST_DONE);
  assign bus_addr_o  = addr_q;
  assign bus_write_o = wr_q && in_xfer;
  assign bus_wdata_o = (beat && wr_q) ? sel_data : '0;
  assign rd_valid_o  = beat && !wr_q;
  assign rd_beat_o   = idx;
  assign rd_data_o   = rd_valid_o ? bus_rdata_i : '0;
endmodule

// File: rtl/burst_bus_ctrl_chk.sv
module burst_bus_ctrl_chk #(
  parameter int ADDR_W = 26,
  parameter int DW     = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              rd_valid_o,
  input logic              bus_req_o,
  input logic              bus_rdy_i,
  input logic [ADDR_W-1:0] bus_addr_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!bus_req_o && !done_o && !rd_valid_o)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && $past(bus_req_o)) |-> $stable(bus_addr_o)); // R4
  AST_BEAT_AFTER_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(bus_rdy_i)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o)); // R7
  AST_DONE_REQ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !$past(bus_req_o)); // R3
endmodule

bind burst_bus_ctrl burst_bus_ctrl_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .done_o     (done_o),
  .rd_valid_o (rd_valid_o),
  .bus_req_o  (bus_req_o),
  .bus_rdy_i  (bus_rdy_i),
  .bus_addr_o (bus_addr_o)
);

// File: tb/tb_burst_bus_ctrl.sv
module tb_burst_bus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 26;
  localparam int DW = 64;
  localparam int NB = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, bus_rdy = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW*NB-1:0] req_line = '0;
  logic [DW-1:0] bus_rdata;
  logic req_ready, done, rd_valid, bus_write, bus_req;
  logic [1:0] rd_beat;
  logic [DW-1:0] rd_data, bus_wdata;
  logic [AW-1:0] bus_addr;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_bus_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_line_i(req_line), .req_ready_o(req_ready),
    .done_o(done), .rd_valid_o(rd_valid), .rd_beat_o(rd_beat), .rd_data_o(rd_data),
    .bus_addr_o(bus_addr), .bus_write_o(bus_write), .bus_req_o(bus_req),
    .bus_wdata_o(bus_wdata), .bus_rdy_i(bus_rdy), .bus_rdata_i(bus_rdata)
  );

  always @(posedge clk) cyc <= cyc + 1;
  assign bus_rdata = {32'h5EED0000 ^ 32'(cyc), 32'(cyc) * 32'd2654435761};

  function automatic logic [DW*NB-1:0] mk_line(input logic [AW-1:0] a);
    logic [DW*NB-1:0] l;
    for (int k = 0; k < NB; k++) l[k*DW +: DW] = {32'hD0D00000 | 32'(k), 32'(a)};
    return l;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // reference model: phase 0 idle, 1 transfer, 2 done
  int m_phase = 0, m_rdys = 0, m_k = 0;
  bit m_beat = 0, m_wr = 0;
  logic [AW-1:0] m_addr;
  logic [DW*NB-1:0] m_line;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_rdys = 0; m_k = 0; m_beat = 0;
    end else begin
      case (m_phase)
        0: if (req_valid) begin
          m_phase = 1; m_rdys = 0; m_k = 0; m_beat = 0;
          m_wr = req_write; m_addr = req_addr; m_line = req_line;
        end
        1: begin
          if (m_beat && m_rdys == NB) begin
            m_phase = 2; m_beat = 0;
          end else begin
            if (m_beat) m_k++;
            m_beat = bus_rdy;
            if (bus_rdy) m_rdys++;
          end
        end
        default: m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(req_ready == (m_phase == 0), "R2 ready", 64'(req_ready), 64'(m_phase == 0));
    chk(bus_req == (m_phase == 1 && m_rdys < NB-1), "R3 bus_req", 64'(bus_req),
        64'(m_phase == 1 && m_rdys < NB-1));
    chk(done == (m_phase == 2), "R7 done", 64'(done), 64'(m_phase == 2));
    chk(rd_valid == (m_beat && !m_wr), "R6/R8 rd_valid", 64'(rd_valid), 64'(m_beat && !m_wr));
    if (m_phase == 1) begin
      chk(bus_addr == m_addr, "R4 addr", 64'(bus_addr), 64'(m_addr));
      chk(bus_write == m_wr, "R4 write", 64'(bus_write), 64'(m_wr));
    end
    if (m_beat && m_wr)
      chk(bus_wdata == m_line[m_k*DW +: DW], "R5 wdata", bus_wdata, m_line[m_k*DW +: DW]);
    if (m_beat && !m_wr) begin
      chk(rd_beat == 2'(m_k), "R6 beat", 64'(rd_beat), 64'(m_k));
      chk(rd_data == bus_rdata, "R6 data", rd_data, bus_rdata);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic burst(input bit wr, input logic [AW-1:0] a, input int g0, input int g1,
                       input int g2, input int g3, input bit hold, input bit extra);
    int g[4];
    g = '{g0, g1, g2, g3};
    req_valid = 1; req_write = wr; req_addr = a; req_line = mk_line(a);
    step();
    if (hold) begin
      req_write = !wr; req_addr = ~a; req_line = ~req_line;
    end else req_valid = 0;
    for (int k = 0; k < NB; k++) begin
      repeat (g[k]) step();
      bus_rdy = 1; step(); bus_rdy = 0;
    end
    if (extra) bus_rdy = 1;  // R8 stray ready in last-beat cycle
    step();
    bus_rdy = extra;          // and in done cycle
    req_valid = 0;
    step();
    bus_rdy = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    chk(req_ready && !bus_req && !bus_write && !rd_valid && !done, "R1 reset",
        64'({req_ready, bus_req, bus_write, rd_valid, done}), 64'b10000);
    step(); rst_n = 1; step();
    burst(0, 26'h0123, 0, 0, 0, 0, 0, 0);
    burst(1, 26'h3ABCD, 2, 0, 3, 1, 0, 0);
    bus_rdy = 1; step(); step(); bus_rdy = 0; step();  // R8 stray readies while idle
    burst(0, 26'h2222, 3, 1, 0, 2, 0, 1);
    burst(1, 26'h1F0F0, 0, 2, 0, 0, 1, 1);  // R2 request held through transfer
    burst(1, 26'h00055, 1, 1, 1, 1, 0, 0);
    burst(0, 26'h3FFFF, 0, 0, 4, 0, 1, 0);
    repeat (3) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule